// File: doc/BRIEF.md
# Erase Timer and Status Reporter

This block sits beside the erase engine of a two-bank flash controller. It gathers block-erase confirm commands into an erase list and holds a restartable start window. When that window lapses with no further confirm, it tells the engine to begin. While an operation is open, it answers each host read of the affected bank with an 8-bit status word. Reads elsewhere are marked as array reads, and the array path supplies the data.

The status word carries five live bits. Bit 7 is the completion flag. Bit 6 is the main toggle. Bit 5 is the failure flag. Bit 3 is the window-expired flag. Bit 2 is the alternate toggle, which marks blocks on the erase list. All other bits read 0. Bank membership is fixed by a split parameter: block numbers below `BANK_SPLIT` are in the low bank, and the rest are in the high bank. The bank of the first confirm becomes the operation bank.

The block also reacts to other commands. It accepts suspend and resume while erasing. It latches a failure reported by the engine until a reset command arrives. A reset command also cancels a pending start window.

Top module: `erase_status_unit`

## Requirements
- R1: A confirm while idle opens the start window, sets the confirmed block's bit in `eraseMask` and fixes the operation bank to that block's bank.
- R2: `eraseStart` pulses high for exactly one clock, `WINDOW_CYCLES` clocks after the clock edge that accepted the last confirm. A confirm for the operation bank during the window adds its block to the list and restarts the count.
- R3: During the window, a confirm for a block in the other bank, or a reset command, abandons the operation: `eraseMask` returns to 0 and `eraseStart` never pulses for it.
- R4: Each read strobe produces `rdValid` on the next clock. Whenever `rdIsStatus` is 0, `rdStatus` is 0. While idle, no read is a status read. After reset, `eraseMask`, `eraseStart`, `eraseHold` and `rdValid` are 0.
- R5: During the window and during erasing, reads of blocks in the operation bank are status reads, and reads of other-bank blocks are not.
- R6: Status bit 3 is 0 during the window and 1 from the start of erasing onward, including while suspended or failed.
- R7: During the window and during erasing, status bit 7 is 0 and status bit 6 inverts on every status read.
- R8: Status bit 2 inverts on every status read of a block on the erase list, and reads 0 for a block not on the list.
- R9: A suspend while erasing raises `eraseHold` on the next clock. While suspended, a read of a listed block returns bit 6 = 1 and a toggling bit 2, and a read of any other block is not a status read. Resume clears `eraseHold`, and bit 6 toggling resumes.
- R10: Engine done with no failure returns to idle and clears the list. Engine done with failure enters a failed state that reports bit 7 = 1 and bit 5 = 1, with bit 6 frozen, and keeps the list. Only a reset command leaves the failed state, and it clears the list.
- R11: A confirm while erasing, suspended or failed is ignored. A suspend is ignored outside erasing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdConfirm | input | 1 | Block-erase confirm pulse |
| cmdBlk | input | BLK_W | Block number of the confirm |
| cmdSuspend | input | 1 | Erase suspend pulse |
| cmdResume | input | 1 | Erase resume pulse |
| cmdReset | input | 1 | Reset command pulse |
| engDone | input | 1 | Engine finished erasing |
| engFail | input | 1 | Qualifies engDone as a failure |
| rdStrobe | input | 1 | Host read of the array |
| rdBlk | input | BLK_W | Block number of the read |
| eraseStart | output | 1 | One-clock pulse telling the engine to begin |
| eraseHold | output | 1 | Engine must pause (suspended) |
| eraseMask | output | NUM_BLOCKS | Erase list, one bit per block |
| rdValid | output | 1 | Read response valid |
| rdIsStatus | output | 1 | Response is the status word, not array data |
| rdStatus | output | 8 | Status word |

## Verification
The bench builds the block with `WINDOW_CYCLES` = 20, `NUM_BLOCKS` = 16 and `BANK_SPLIT` = 4. The short window lets the bench count every clock up to the start pulse, both after a single confirm and after a restarting confirm. It also lets the bench wait out whole windows after an abort to show that no start follows. The uneven split puts blocks 0 to 3 in one bank and 4 to 15 in the other, so cross-bank aborts and array-read routing can be reached from either side.

// File: rtl/esr_pkg.sv
package esr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WINDOW,
    PH_ERASE,
    PH_SUSP,
    PH_FAIL
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    phase_e phase;
    logic   listAdd;
    logic   listClear;
    logic   bankLoad;
  } ctrl_strobe_t;

  localparam int ST_POLL   = 7;
  localparam int ST_TOGGLE = 6;
  localparam int ST_ERR    = 5;
  localparam int ST_TIMER  = 3;
  localparam int ST_ALT    = 2;

endpackage

// File: rtl/esr_window_timer.sv
module esr_window_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cntQ <= '0;
    else if (load)              cntQ <= CW'(CYCLES);
    else if (run && cntQ != '0) cntQ <= cntQ - 1'b1;
  end

  assign expire = run && (cntQ == CW'(1));
endmodule

// File: rtl/esr_ctrl.sv
module esr_ctrl
  import esr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdConfirm,
  input  logic         cmdSuspend,
  input  logic         cmdResume,
  input  logic         cmdReset,
  input  logic         engDone,
  input  logic         engFail,
  input  logic         sameBank,
  input  logic         windowExpire,
  output ctrl_strobe_t strobe,
  output logic         timerLoad,
  output logic         timerRun,
  output logic         eraseStart,
  output logic         eraseHold
);
  phase_e phaseQ, phaseD;
  logic   listAdd, listClear, bankLoad, startQ;

  always_comb begin
    phaseD    = phaseQ;
    listAdd   = 1'b0;
    listClear = 1'b0;
    bankLoad  = 1'b0;
    timerLoad = 1'b0;
    unique case (phaseQ)
      PH_IDLE: if (cmdConfirm) begin
        phaseD    = PH_WINDOW;
        listAdd   = 1'b1;
        bankLoad  = 1'b1;
        timerLoad = 1'b1;
      end
      PH_WINDOW: begin
        if (cmdReset || (cmdConfirm && !sameBank)) begin
          phaseD    = PH_IDLE;
          listClear = 1'b1;
        end else if (cmdConfirm) begin
          listAdd   = 1'b1;
          timerLoad = 1'b1;
        end else if (windowExpire) begin
          phaseD = PH_ERASE;
        end
      end
      PH_ERASE: begin
        if (engDone) begin
          phaseD    = engFail ? PH_FAIL : PH_IDLE;
          listClear = !engFail;
        end else if (cmdSuspend) begin
          phaseD = PH_SUSP;
        end
      end
      PH_SUSP: if (cmdResume) phaseD = PH_ERASE;
      PH_FAIL: if (cmdReset) begin
        phaseD    = PH_IDLE;
        listClear = 1'b1;
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      startQ <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      startQ <= (phaseQ == PH_WINDOW) && (phaseD == PH_ERASE);
    end
  end

  assign timerRun   = (phaseQ == PH_WINDOW);
  assign eraseStart = startQ;
  assign eraseHold  = (phaseQ == PH_SUSP);

  always_comb begin
    strobe.phase     = phaseQ;
    strobe.listAdd   = listAdd;
    strobe.listClear = listClear;
    strobe.bankLoad  = bankLoad;
  end
endmodule

// File: rtl/esr_datapath.sv
module esr_datapath
  import esr_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int BANK_SPLIT = 4,
  parameter int BLK_W      = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrl_strobe_t          strobe,
  input  logic [BLK_W-1:0]      cmdBlk,
  input  logic                  rdStrobe,
  input  logic [BLK_W-1:0]      rdBlk,
  output logic                  sameBank,
  output logic [NUM_BLOCKS-1:0] eraseMask,
  output logic                  rdValid,
  output logic                  rdIsStatus,
  output logic [7:0]            rdStatus
);
  localparam logic [BLK_W:0] SPLIT = (BLK_W+1)'(BANK_SPLIT);

  logic [NUM_BLOCKS-1:0] listQ, cmdHit, rdHit;
  logic opBankQ, tog6Q, tog2Q;
  logic cmdBank, rdBank, rdBankHit, inList;
  logic isStat, flip6, flip2;
  logic [7:0] word;
  logic validQ, isStatQ;
  logic [7:0] wordQ;

  for (genvar gi = 0; gi < NUM_BLOCKS; gi++) begin : g_blk
    assign cmdHit[gi] = (cmdBlk == BLK_W'(gi));
    assign rdHit[gi]  = (rdBlk == BLK_W'(gi));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               listQ[gi] <= 1'b0;
      else if (strobe.listClear)               listQ[gi] <= 1'b0;
      else if (strobe.listAdd && cmdHit[gi])   listQ[gi] <= 1'b1;
    end
  end

  assign cmdBank   = ({1'b0, cmdBlk} >= SPLIT);
  assign rdBank    = ({1'b0, rdBlk} >= SPLIT);
  assign sameBank  = (cmdBank == opBankQ);
  assign rdBankHit = (rdBank == opBankQ);
  assign inList    = |(listQ & rdHit);

  always_comb begin
    isStat = 1'b0;
    flip6  = 1'b0;
    flip2  = 1'b0;
    word   = '0;
    unique case (strobe.phase)
      PH_WINDOW, PH_ERASE: begin
        isStat         = rdBankHit;
        word[ST_TOGGLE] = tog6Q;
        word[ST_TIMER]  = (strobe.phase == PH_ERASE);
        word[ST_ALT]    = inList & tog2Q;
        flip6          = isStat;
        flip2          = isStat & inList;
      end
      PH_SUSP: begin
        isStat          = inList;
        word[ST_TOGGLE] = 1'b1;
        word[ST_TIMER]  = 1'b1;
        word[ST_ALT]    = tog2Q;
        flip2           = isStat;
      end
      PH_FAIL: begin
        isStat          = rdBankHit;
        word[ST_POLL]   = 1'b1;
        word[ST_ERR]    = 1'b1;
        word[ST_TIMER]  = 1'b1;
        word[ST_TOGGLE] = tog6Q;
        word[ST_ALT]    = inList & tog2Q;
        flip2           = isStat & inList;
      end
      default: isStat = 1'b0;
    endcase
    if (!isStat) word = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opBankQ <= 1'b0;
      tog6Q   <= 1'b0;
      tog2Q   <= 1'b0;
      validQ  <= 1'b0;
      isStatQ <= 1'b0;
      wordQ   <= '0;
    end else begin
      if (strobe.bankLoad) opBankQ <= cmdBank;
      validQ <= rdStrobe;
      if (rdStrobe) begin
        isStatQ <= isStat;
        wordQ   <= word;
        if (flip6) tog6Q <= ~tog6Q;
        if (flip2) tog2Q <= ~tog2Q;
      end else begin
        isStatQ <= 1'b0;
        wordQ   <= '0;
      end
    end
  end

  assign eraseMask  = listQ;
  assign rdValid    = validQ;
  assign rdIsStatus = isStatQ;
  assign rdStatus   = wordQ;
endmodule

// File: rtl/erase_status_unit.sv
module erase_status_unit
  import esr_pkg::*;
#(
  parameter int NUM_BLOCKS    = 16,
  parameter int BANK_SPLIT    = 4,
  parameter int WINDOW_CYCLES = 5000,
  localparam int BLK_W        = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdConfirm,
  input  logic [BLK_W-1:0]      cmdBlk,
  input  logic                  cmdSuspend,
  input  logic                  cmdResume,
  input  logic                  cmdReset,
  input  logic                  engDone,
  input  logic                  engFail,
  input  logic                  rdStrobe,
  input  logic [BLK_W-1:0]      rdBlk,
  output logic                  eraseStart,
  output logic                  eraseHold,
  output logic [NUM_BLOCKS-1:0] eraseMask,
  output logic                  rdValid,
  output logic                  rdIsStatus,
  output logic [7:0]            rdStatus
);
  ctrl_strobe_t ctlStrobe;
  logic sameBank, timerLoad, timerRun, windowExpire;

  esr_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdConfirm(cmdConfirm), .cmdSuspend(cmdSuspend), .cmdResume(cmdResume),
    .cmdReset(cmdReset), .engDone(engDone), .engFail(engFail),
    .sameBank(sameBank), .windowExpire(windowExpire),
    .strobe(ctlStrobe), .timerLoad(timerLoad), .timerRun(timerRun),
    .eraseStart(eraseStart), .eraseHold(eraseHold)
  );

  esr_window_timer #(.CYCLES(WINDOW_CYCLES)) uTimer (
    .clk(clk), .rstN(rstN), .load(timerLoad), .run(timerRun),
    .expire(windowExpire)
  );

  esr_datapath #(
    .NUM_BLOCKS(NUM_BLOCKS), .BANK_SPLIT(BANK_SPLIT), .BLK_W(BLK_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(ctlStrobe), .cmdBlk(cmdBlk),
    .rdStrobe(rdStrobe), .rdBlk(rdBlk), .sameBank(sameBank),
    .eraseMask(eraseMask), .rdValid(rdValid), .rdIsStatus(rdIsStatus),
    .rdStatus(rdStatus)
  );
endmodule

// File: rtl/esr_checker.sv
module esr_checker
  import esr_pkg::*;
#(
  parameter int NUM_BLOCKS = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  cmdSuspend,
  input logic                  engDone,
  input logic                  rdStrobe,
  input logic                  rdValid,
  input logic                  rdIsStatus,
  input logic [7:0]            rdStatus,
  input logic                  eraseStart,
  input logic                  eraseHold,
  input logic [NUM_BLOCKS-1:0] eraseMask,
  input ctrl_strobe_t          ctlStrobe
);
  // R4
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> rdValid);

  // R4
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdIsStatus |-> (rdStatus == 8'h00));

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |=> !eraseStart);

  // R2
  start_from_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> ($past(ctlStrobe.phase) == PH_WINDOW && ctlStrobe.phase == PH_ERASE));

  // R9
  suspend_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStrobe.phase == PH_ERASE && cmdSuspend && !engDone) |=> eraseHold);

  // R10
  err_implies_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIsStatus && rdStatus[ST_ERR]) |-> rdStatus[ST_POLL]);

  // R3
  idle_list_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStrobe.phase == PH_IDLE) |-> (eraseMask == '0));

  // R6
  window_timer_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIsStatus && $past(ctlStrobe.phase) == PH_WINDOW) |-> !rdStatus[ST_TIMER]);
endmodule

bind erase_status_unit esr_checker #(.NUM_BLOCKS(NUM_BLOCKS)) chkInst (
  .clk(clk), .rstN(rstN), .cmdSuspend(cmdSuspend), .engDone(engDone),
  .rdStrobe(rdStrobe), .rdValid(rdValid), .rdIsStatus(rdIsStatus),
  .rdStatus(rdStatus), .eraseStart(eraseStart), .eraseHold(eraseHold),
  .eraseMask(eraseMask), .ctlStrobe(ctlStrobe)
);

// File: tb/tb_erase_status_unit.sv
module tb_erase_status_unit;
  localparam int NB = 16;
  localparam int W  = 20;
  localparam int BW = $clog2(NB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdConfirm = 0, cmdSuspend = 0, cmdResume = 0, cmdReset = 0;
  logic engDone = 0, engFail = 0, rdStrobe = 0;
  logic [BW-1:0] cmdBlk = '0, rdBlk = '0;
  logic eraseStart, eraseHold, rdValid, rdIsStatus;
  logic [NB-1:0] eraseMask;
  logic [7:0] rdStatus;

  int checks = 0, errors = 0, startCount = 0;
  logic t6 = 1'b0, t2 = 1'b0;
  bit finished = 0;

  typedef struct {
    logic       isStat;
    logic [7:0] word;
    string      tag;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  erase_status_unit #(.NUM_BLOCKS(NB), .BANK_SPLIT(4), .WINDOW_CYCLES(W)) dut (
    .clk(clk), .rstN(rstN), .cmdConfirm(cmdConfirm), .cmdBlk(cmdBlk),
    .cmdSuspend(cmdSuspend), .cmdResume(cmdResume), .cmdReset(cmdReset),
    .engDone(engDone), .engFail(engFail), .rdStrobe(rdStrobe), .rdBlk(rdBlk),
    .eraseStart(eraseStart), .eraseHold(eraseHold), .eraseMask(eraseMask),
    .rdValid(rdValid), .rdIsStatus(rdIsStatus), .rdStatus(rdStatus)
  );

  // monitor: pop expected read responses
  always @(negedge clk) begin
    exp_t e;
    if (rstN && eraseStart) startCount++;
    if (rstN && rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected response: actual %b/%h expected none", rdIsStatus, rdStatus);
      end else begin
        e = expQ.pop_front();
        if (rdIsStatus !== e.isStat || rdStatus !== e.word) begin
          errors++;
          $display("FAIL %s: actual %b/%h expected %b/%h", e.tag, rdIsStatus, rdStatus, e.isStat, e.word);
        end
      end
    end
  end

  task automatic chkVal(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 confirm 1 suspend 2 resume 3 reset 4 done-ok 5 done-fail
  task automatic pulse(input int kind, input int blk);
    @(negedge clk);
    cmdBlk = BW'(blk);
    case (kind)
      0: cmdConfirm = 1;
      1: cmdSuspend = 1;
      2: cmdResume = 1;
      3: cmdReset = 1;
      4: engDone = 1;
      default: begin engDone = 1; engFail = 1; end
    endcase
    @(negedge clk);
    cmdConfirm = 0; cmdSuspend = 0; cmdResume = 0; cmdReset = 0;
    engDone = 0; engFail = 0;
  endtask

  // m6: 0 toggling, 1 held at one, 2 frozen; m2: 0 zero, 1 toggling
  task automatic rdExpect(input int blk, input logic isStat, input logic b7,
                          input logic b5, input logic b3, input int m6,
                          input int m2, input string tag);
    exp_t e;
    e.isStat = isStat;
    e.word = 8'h00;
    e.tag = tag;
    if (isStat) begin
      e.word[7] = b7;
      e.word[5] = b5;
      e.word[3] = b3;
      case (m6)
        0: begin e.word[6] = t6; t6 = ~t6; end
        1: e.word[6] = 1'b1;
        default: e.word[6] = t6;
      endcase
      if (m2 == 1) begin e.word[2] = t2; t2 = ~t2; end
    end
    expQ.push_back(e);
    @(negedge clk);
    rdStrobe = 1;
    rdBlk = BW'(blk);
    @(negedge clk);
    rdStrobe = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int early;
    waitCyc(3);
    rstN = 1;
    waitCyc(1);
    chkVal(eraseMask, 0, "R4 reset mask");
    chkVal(eraseStart, 0, "R4 reset start");
    chkVal(eraseHold, 0, "R4 reset hold");
    chkVal(rdValid, 0, "R4 reset valid");
    rdExpect(5, 0, 0, 0, 0, 0, 0, "R4 idle read");

    // window, then cross-bank abort
    pulse(0, 6);
    chkVal(eraseMask, 32'h40, "R1 first confirm mask");
    rdExpect(6, 1, 0, 0, 0, 0, 1, "R6 R7 R8 window listed");
    rdExpect(9, 1, 0, 0, 0, 0, 0, "R5 R8 window unlisted");
    rdExpect(1, 0, 0, 0, 0, 0, 0, "R5 window other bank");
    pulse(0, 2);
    chkVal(eraseMask, 0, "R3 cross-bank abort mask");
    waitCyc(W + 5);
    chkVal(startCount, 0, "R3 no start after abort");
    rdExpect(6, 0, 0, 0, 0, 0, 0, "R3 read after abort");

    // restart and exact start timing
    pulse(0, 8);
    waitCyc(8);
    pulse(0, 10);
    chkVal(eraseMask, 32'h500, "R2 added block");
    early = 0;
    for (int i = 1; i < W; i++) begin
      @(negedge clk);
      if (eraseStart) early++;
    end
    chkVal(early, 0, "R2 no start before restarted window");
    @(negedge clk);
    chkVal(eraseStart, 1, "R2 start on window expiry");
    rdExpect(8, 1, 0, 0, 1, 0, 1, "R6 R7 erase listed");
    rdExpect(12, 1, 0, 0, 1, 0, 0, "R8 erase unlisted");
    rdExpect(0, 0, 0, 0, 0, 0, 0, "R5 erase other bank");
    pulse(0, 12);
    chkVal(eraseMask, 32'h500, "R11 confirm while erasing");
    chkVal(startCount, 1, "R2 single start");

    // suspend / resume
    pulse(1, 0);
    chkVal(eraseHold, 1, "R9 hold after suspend");
    rdExpect(8, 1, 0, 0, 1, 1, 1, "R9 suspended listed");
    rdExpect(8, 1, 0, 0, 1, 1, 1, "R9 suspended listed again");
    rdExpect(12, 0, 0, 0, 0, 0, 0, "R9 suspended unlisted");
    pulse(0, 12);
    chkVal(eraseMask, 32'h500, "R11 confirm while suspended");
    pulse(2, 0);
    chkVal(eraseHold, 0, "R9 hold after resume");
    rdExpect(8, 1, 0, 0, 1, 0, 1, "R9 resumed toggling");
    pulse(4, 0);
    chkVal(eraseMask, 0, "R10 list cleared on success");
    rdExpect(8, 0, 0, 0, 0, 0, 0, "R10 idle after success");

    // failure path in the low bank
    pulse(0, 1);
    waitCyc(W + 2);
    chkVal(startCount, 2, "R2 second start");
    pulse(1, 0);
    chkVal(eraseHold, 1, "R9 hold in low bank");
    pulse(2, 0);
    pulse(5, 0);
    chkVal(eraseMask, 32'h2, "R10 list kept on failure");
    rdExpect(1, 1, 1, 1, 1, 2, 1, "R10 failed listed");
    rdExpect(1, 1, 1, 1, 1, 2, 1, "R10 failed frozen toggle");
    rdExpect(3, 1, 1, 1, 1, 2, 0, "R10 failed unlisted");
    pulse(1, 0);
    chkVal(eraseHold, 0, "R11 suspend ignored when failed");
    pulse(0, 2);
    chkVal(eraseMask, 32'h2, "R11 confirm ignored when failed");
    rdExpect(1, 1, 1, 1, 1, 2, 1, "R10 still failed");
    pulse(3, 0);
    chkVal(eraseMask, 0, "R10 reset clears failure");
    rdExpect(1, 0, 0, 0, 0, 0, 0, "R10 idle after reset");

    // reset command in window
    pulse(0, 5);
    pulse(3, 0);
    chkVal(eraseMask, 0, "R3 reset aborts window");
    waitCyc(W + 5);
    chkVal(startCount, 2, "R3 no start after reset abort");

    waitCyc(2);
    chkVal(expQ.size(), 0, "R4 all reads answered");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule